// File: doc/BRIEF.md
# Slot Relocation Recovery Controller

This block sequences the repair of one faulty reconfigurable slot in a fabric of `N_SLOTS` slots. A fault report arrives as a single-beat valid/ready transfer carrying the slot index and a flag that says whether the fault is permanent. Every repair runs in three phases in order: localization, reconfiguration, and recovery. Communications stay paused from acceptance until the repair ends.

A transient fault is cured by reloading the function image into the same slot. A permanent fault moves the function elsewhere. The controller loads the function image into the lowest-index free slot and pulses a mode switch so the system uses the relocated copy. It then loads a test image into the old slot and runs self-test there. A passing slot goes back to the free pool, and a failing one is marked defective for good. In both cases the repaired unit is then held in reset for one cycle and resynchronized. The configuration port, the self-test engine and the synchronizer are external and are reached through request/done handshakes.

The report channel accepts a beat only while the controller is idle. A sender that holds `flt_valid` high during a repair keeps its payload stable and is served once `flt_ready` returns. Each handshake wait is bounded by a cycle timeout that aborts the repair.

Top module: `slot_repair_ctrl`

## Requirements
- R1: `flt_ready` is high exactly when the controller is idle. A beat transfers when `flt_valid` and `flt_ready` are both high at a clock edge. `comm_pause` is high from the next cycle until the controller is idle again, and `flt_ready` is low in all of those cycles.
- R2: For a transient fault (`flt_perm`=0), `cfg_req` targets the faulted slot with `cfg_test_img`=0. No mode switch and no self-test follow, and the slot map is left unchanged.
- R3: For a permanent fault, `cfg_req` targets the lowest-index free slot with `cfg_test_img`=0.
- R4: After `cfg_done` for a permanent relocation, `mode_switch` pulses for exactly one cycle, with `mode_old_slot` set to the faulted slot and `mode_new_slot` set to the relocated slot. From that cycle the relocated slot's bit in `slot_free` is 0.
- R5: After the mode switch, `cfg_req` targets the faulted slot with `cfg_test_img`=1. Once that completes, `bist_req` is raised with `bist_slot` set to the faulted slot.
- R6: When `bist_done` arrives with `bist_pass`=1, the faulted slot becomes free. With `bist_pass`=0 its `slot_bad` bit is set and never clears, and no slot is ever free and bad at the same time.
- R7: Recovery pulses `unit_rst` for one cycle, with `unit_slot` set to the repaired slot (the same slot for a transient fault, the relocated slot for a permanent one). `sync_req` is raised in the next cycle and held until `sync_done`. The cycle after that carries a one-cycle `repair_ok` pulse, and the controller is idle in the cycle that follows.
- R8: If a permanent fault finds no free slot, `unrecoverable` pulses for one cycle and the controller returns to idle without raising `cfg_req` or `mode_switch`.
- R9: If a wait on `cfg_done`, `bist_done` or `sync_done` lasts `TIMEOUT` cycles with no done, `abort` pulses in the next cycle and the controller returns to idle. A done that arrives in the last allowed cycle of the wait is honoured.
- R10: While `cfg_req` waits, it stays high and `cfg_slot` and `cfg_test_img` stay stable, unless the wait aborts.
- R11: After reset the controller is idle with no request outputs high. `slot_free` is the inverse of `INIT_BUSY` and `slot_bad` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flt_valid | input | 1 | Fault report valid |
| flt_ready | output | 1 | Fault report accepted when high with valid |
| flt_slot | input | SLOT_W | Faulted slot index |
| flt_perm | input | 1 | 1 = permanent fault, 0 = transient |
| comm_pause | output | 1 | Communications paused during repair |
| cfg_req | output | 1 | Configuration load request |
| cfg_slot | output | SLOT_W | Slot to load |
| cfg_test_img | output | 1 | 1 = test image, 0 = function image |
| cfg_done | input | 1 | Configuration load finished |
| mode_switch | output | 1 | One-cycle operating mode change pulse |
| mode_old_slot | output | SLOT_W | Slot leaving service |
| mode_new_slot | output | SLOT_W | Slot entering service |
| bist_req | output | 1 | Self-test request |
| bist_slot | output | SLOT_W | Slot under test |
| bist_done | input | 1 | Self-test finished |
| bist_pass | input | 1 | Self-test verdict, valid with bist_done |
| unit_rst | output | 1 | One-cycle reset of the repaired unit |
| unit_slot | output | SLOT_W | Slot being reset and synchronized |
| sync_req | output | 1 | Resynchronization request |
| sync_done | input | 1 | Resynchronization finished |
| repair_ok | output | 1 | One-cycle pulse at successful completion |
| unrecoverable | output | 1 | One-cycle pulse when no free slot exists |
| abort | output | 1 | One-cycle pulse when a wait timed out |
| slot_free | output | N_SLOTS | Per-slot free flags |
| slot_bad | output | N_SLOTS | Per-slot defective flags |

## Verification
Two events can fall in the same cycle: the arrival of a done and the expiry of the wait timer. The bench counts cycles from the first cycle that `cfg_req` is visible. It raises `cfg_done` in exactly the last allowed cycle and expects recovery to start with no `abort`. In a separate run it withholds the done entirely and expects `abort` exactly `TIMEOUT` cycles later. A second pairing is a new report held on the channel while the previous repair finishes. That report must wait for the `repair_ok` cycle to pass and then transfer, and the next `cfg_slot` must match its payload.

// File: rtl/srr_pkg.sv
package srr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_LOCATE, ST_CFG_NEW, ST_MODE, ST_CFG_TEST,
    ST_BIST, ST_RST, ST_SYNC, ST_DONE, ST_NOSLOT, ST_ABORT
  } srr_state_e;

  typedef enum logic [1:0] {
    SL_FREE = 2'd0,
    SL_BUSY = 2'd1,
    SL_BAD  = 2'd2
  } slot_stat_e;
endpackage

// File: rtl/srr_slot_map.sv
module srr_slot_map
  import srr_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int SLOT_W = 2,
  parameter logic [N_SLOTS-1:0] INIT_BUSY = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SLOT_W-1:0]  wr_idx,
  input  slot_stat_e         wr_stat,
  output logic [N_SLOTS-1:0] free_mask,
  output logic [N_SLOTS-1:0] bad_mask
);
  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    slot_stat_e stat_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= INIT_BUSY[g] ? SL_BUSY : SL_FREE;
      else if (wr_en && (int'(wr_idx) == g) && (stat_q != SL_BAD)) stat_q <= wr_stat;
    end
    assign free_mask[g] = (stat_q == SL_FREE);
    assign bad_mask[g]  = (stat_q == SL_BAD);
  end
endmodule

// File: rtl/srr_free_pick.sv
module srr_free_pick #(
  parameter int N_SLOTS = 4,
  parameter int SLOT_W = 2
) (
  input  logic [N_SLOTS-1:0] free_mask,
  output logic               found,
  output logic [SLOT_W-1:0]  idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (free_mask[i]) begin
        found = 1'b1;
        idx   = SLOT_W'(i);
      end
    end
  end
endmodule

// File: rtl/srr_wait_timer.sv
module srr_wait_timer #(
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic expired
);
  localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == LAST);
endmodule

// File: rtl/slot_repair_ctrl.sv
module slot_repair_ctrl
  import srr_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int TIMEOUT = 64,
  parameter logic [N_SLOTS-1:0] INIT_BUSY = 4'b0011,
  parameter int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flt_valid,
  output logic               flt_ready,
  input  logic [SLOT_W-1:0]  flt_slot,
  input  logic               flt_perm,
  output logic               comm_pause,
  output logic               cfg_req,
  output logic [SLOT_W-1:0]  cfg_slot,
  output logic               cfg_test_img,
  input  logic               cfg_done,
  output logic               mode_switch,
  output logic [SLOT_W-1:0]  mode_old_slot,
  output logic [SLOT_W-1:0]  mode_new_slot,
  output logic               bist_req,
  output logic [SLOT_W-1:0]  bist_slot,
  input  logic               bist_done,
  input  logic               bist_pass,
  output logic               unit_rst,
  output logic [SLOT_W-1:0]  unit_slot,
  output logic               sync_req,
  input  logic               sync_done,
  output logic               repair_ok,
  output logic               unrecoverable,
  output logic               abort,
  output logic [N_SLOTS-1:0] slot_free,
  output logic [N_SLOTS-1:0] slot_bad
);
  srr_state_e state_q, state_d;
  logic [SLOT_W-1:0] fault_q, tgt_q;
  logic perm_q;
  logic pick_found, expired, waiting;
  logic [SLOT_W-1:0] pick_idx;
  logic map_wr;
  logic [SLOT_W-1:0] map_idx;
  slot_stat_e map_stat;

  srr_slot_map #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W), .INIT_BUSY(INIT_BUSY)) u_map (
    .clk(clk), .rst_n(rst_n), .wr_en(map_wr), .wr_idx(map_idx), .wr_stat(map_stat),
    .free_mask(slot_free), .bad_mask(slot_bad)
  );

  srr_free_pick #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) u_pick (
    .free_mask(slot_free), .found(pick_found), .idx(pick_idx)
  );

  assign waiting = (state_q == ST_CFG_NEW) || (state_q == ST_CFG_TEST) ||
                   (state_q == ST_BIST) || (state_q == ST_SYNC);

  srr_wait_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(!waiting || (state_d != state_q)), .expired(expired)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (flt_valid) state_d = ST_LOCATE;
      ST_LOCATE:   if (!perm_q || pick_found) state_d = ST_CFG_NEW;
                   else state_d = ST_NOSLOT;
      ST_CFG_NEW:  if (cfg_done) state_d = perm_q ? ST_MODE : ST_RST;
                   else if (expired) state_d = ST_ABORT;
      ST_MODE:     state_d = ST_CFG_TEST;
      ST_CFG_TEST: if (cfg_done) state_d = ST_BIST;
                   else if (expired) state_d = ST_ABORT;
      ST_BIST:     if (bist_done) state_d = ST_RST;
                   else if (expired) state_d = ST_ABORT;
      ST_RST:      state_d = ST_SYNC;
      ST_SYNC:     if (sync_done) state_d = ST_DONE;
                   else if (expired) state_d = ST_ABORT;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fault_q <= '0;
      tgt_q   <= '0;
      perm_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && flt_valid) begin
        fault_q <= flt_slot;
        perm_q  <= flt_perm;
      end
      if (state_q == ST_LOCATE) tgt_q <= perm_q ? pick_idx : fault_q;
    end
  end

  always_comb begin
    map_wr   = 1'b0;
    map_idx  = tgt_q;
    map_stat = SL_BUSY;
    if (state_q == ST_CFG_NEW && cfg_done && perm_q) begin
      map_wr = 1'b1;
    end else if (state_q == ST_BIST && bist_done) begin
      map_wr   = 1'b1;
      map_idx  = fault_q;
      map_stat = bist_pass ? SL_FREE : SL_BAD;
    end
  end

  assign flt_ready     = (state_q == ST_IDLE);
  assign comm_pause    = (state_q != ST_IDLE);
  assign cfg_req       = (state_q == ST_CFG_NEW) || (state_q == ST_CFG_TEST);
  assign cfg_test_img  = (state_q == ST_CFG_TEST);
  assign cfg_slot      = (state_q == ST_CFG_TEST) ? fault_q : tgt_q;
  assign mode_switch   = (state_q == ST_MODE);
  assign mode_old_slot = fault_q;
  assign mode_new_slot = tgt_q;
  assign bist_req      = (state_q == ST_BIST);
  assign bist_slot     = fault_q;
  assign unit_rst      = (state_q == ST_RST);
  assign unit_slot     = tgt_q;
  assign sync_req      = (state_q == ST_SYNC);
  assign repair_ok     = (state_q == ST_DONE);
  assign unrecoverable = (state_q == ST_NOSLOT);
  assign abort         = (state_q == ST_ABORT);
endmodule

// File: rtl/srr_checker.sv
module srr_checker #(
  parameter int N_SLOTS = 4,
  parameter int SLOT_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flt_valid,
  input logic               flt_ready,
  input logic               comm_pause,
  input logic               cfg_req,
  input logic [SLOT_W-1:0]  cfg_slot,
  input logic               cfg_test_img,
  input logic               cfg_done,
  input logic               mode_switch,
  input logic               bist_req,
  input logic               unit_rst,
  input logic               sync_req,
  input logic               unrecoverable,
  input logic               abort,
  input logic [N_SLOTS-1:0] slot_free,
  input logic [N_SLOTS-1:0] slot_bad
);
  assert_accept_pause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && flt_ready |=> comm_pause);
  assert_ready_unpaused_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flt_ready |-> !comm_pause);
  assert_mode_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_switch |=> !mode_switch);
  assert_free_bad_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_free & slot_bad) == '0);
  for (genvar g = 0; g < N_SLOTS; g++) begin : g_sticky
    assert_bad_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      slot_bad[g] |=> slot_bad[g]);
  end
  assert_rst_then_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unit_rst |=> sync_req);
  assert_one_action_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_req, mode_switch, bist_req, unit_rst, sync_req}));
  assert_noslot_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unrecoverable |-> !cfg_req && !mode_switch && $past(!cfg_req));
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_done |=> abort || (cfg_req && $stable(cfg_slot) && $stable(cfg_test_img)));
endmodule

bind slot_repair_ctrl srr_checker #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) u_srr_chk (
  .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_ready(flt_ready),
  .comm_pause(comm_pause), .cfg_req(cfg_req), .cfg_slot(cfg_slot),
  .cfg_test_img(cfg_test_img), .cfg_done(cfg_done), .mode_switch(mode_switch),
  .bist_req(bist_req), .unit_rst(unit_rst), .sync_req(sync_req),
  .unrecoverable(unrecoverable), .abort(abort), .slot_free(slot_free), .slot_bad(slot_bad)
);

// File: tb/slot_repair_ctrl_bench.sv
module slot_repair_ctrl_bench;
  localparam int N = 4;
  localparam int SW = 2;
  localparam int TO = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flt_valid = 1'b0, flt_perm = 1'b0;
  logic [SW-1:0] flt_slot = '0;
  logic cfg_done = 1'b0, bist_done = 1'b0, bist_pass = 1'b0, sync_done = 1'b0;
  logic flt_ready, comm_pause, cfg_req, cfg_test_img, mode_switch, bist_req;
  logic unit_rst, sync_req, repair_ok, unrecoverable, abort;
  logic [SW-1:0] cfg_slot, mode_old_slot, mode_new_slot, bist_slot, unit_slot;
  logic [N-1:0] slot_free, slot_bad;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  slot_repair_ctrl #(.N_SLOTS(N), .TIMEOUT(TO), .INIT_BUSY(4'b0011)) u_slot_repair_ctrl (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_ready(flt_ready),
    .flt_slot(flt_slot), .flt_perm(flt_perm), .comm_pause(comm_pause),
    .cfg_req(cfg_req), .cfg_slot(cfg_slot), .cfg_test_img(cfg_test_img), .cfg_done(cfg_done),
    .mode_switch(mode_switch), .mode_old_slot(mode_old_slot), .mode_new_slot(mode_new_slot),
    .bist_req(bist_req), .bist_slot(bist_slot), .bist_done(bist_done), .bist_pass(bist_pass),
    .unit_rst(unit_rst), .unit_slot(unit_slot), .sync_req(sync_req), .sync_done(sync_done),
    .repair_ok(repair_ok), .unrecoverable(unrecoverable), .abort(abort),
    .slot_free(slot_free), .slot_bad(slot_bad)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic sig(input int code);
    case (code)
      0: return cfg_req;
      1: return mode_switch;
      2: return bist_req;
      3: return unit_rst;
      4: return sync_req;
      5: return repair_ok;
      6: return unrecoverable;
      default: return abort;
    endcase
  endfunction

  task automatic wait_hi(input int code, input string req);
    bit seen = 0;
    for (int i = 0; i < 200; i++) begin
      if (sig(code)) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(req, 32'(seen), 32'd1);
  endtask

  task automatic send(input logic [SW-1:0] s, input logic p);
    @(negedge clk);
    flt_valid = 1'b1; flt_slot = s; flt_perm = p;
    while (!flt_ready) @(negedge clk);
    @(posedge clk); #1;
    flt_valid = 1'b0;
  endtask

  task automatic pulse_cfg();
    cfg_done = 1'b1; @(negedge clk); cfg_done = 1'b0;
  endtask

  task automatic finish_recovery(input logic [SW-1:0] s, input string req);
    wait_hi(3, req);
    chk({req, " unit_slot"}, 32'(unit_slot), 32'(s));
    @(negedge clk);
    chk("R7 sync follows reset", 32'(sync_req), 32'd1);
    sync_done = 1'b1; @(negedge clk); sync_done = 1'b0;
    chk("R7 repair_ok pulse", 32'(repair_ok), 32'd1);
    @(negedge clk);
    chk("R7 pause released", 32'(comm_pause), 32'd0);
    chk("R1 ready after repair", 32'(flt_ready), 32'd1);
  endtask

  task automatic t_reset();
    chk("R11 ready", 32'(flt_ready), 32'd1);
    chk("R11 no requests", 32'({cfg_req, bist_req, sync_req, mode_switch, unit_rst}), 32'd0);
    chk("R11 free map", 32'(slot_free), 32'b1100);
    chk("R11 bad map", 32'(slot_bad), 32'd0);
  endtask

  task automatic t_transient();
    send(2'd1, 1'b0);
    chk("R1 pause after accept", 32'(comm_pause), 32'd1);
    chk("R1 not ready in repair", 32'(flt_ready), 32'd0);
    wait_hi(0, "R2 cfg_req");
    chk("R2 cfg slot", 32'(cfg_slot), 32'd1);
    chk("R2 function image", 32'(cfg_test_img), 32'd0);
    repeat (3) @(negedge clk);
    chk("R10 cfg held", 32'({cfg_req, cfg_slot}), 32'({1'b1, 2'd1}));
    pulse_cfg();
    chk("R2 no mode switch", 32'(mode_switch), 32'd0);
    finish_recovery(2'd1, "R7 transient reset");
    chk("R2 map unchanged", 32'(slot_free), 32'b1100);
  endtask

  task automatic t_perm(input logic [SW-1:0] s, input logic [SW-1:0] exp_new, input logic pass,
                        input logic [N-1:0] exp_free, input logic [N-1:0] exp_bad);
    send(s, 1'b1);
    wait_hi(0, "R3 cfg_req");
    chk("R3 lowest free slot", 32'(cfg_slot), 32'(exp_new));
    chk("R3 function image", 32'(cfg_test_img), 32'd0);
    pulse_cfg();
    chk("R4 mode switch", 32'(mode_switch), 32'd1);
    chk("R4 old slot", 32'(mode_old_slot), 32'(s));
    chk("R4 new slot", 32'(mode_new_slot), 32'(exp_new));
    chk("R4 relocated busy", 32'(slot_free[exp_new]), 32'd0);
    @(negedge clk);
    chk("R4 mode one cycle", 32'(mode_switch), 32'd0);
    chk("R5 test load req", 32'({cfg_req, cfg_test_img}), 32'b11);
    chk("R5 test slot", 32'(cfg_slot), 32'(s));
    pulse_cfg();
    chk("R5 bist req", 32'(bist_req), 32'd1);
    chk("R5 bist slot", 32'(bist_slot), 32'(s));
    bist_pass = pass; bist_done = 1'b1; @(negedge clk); bist_done = 1'b0; bist_pass = 1'b0;
    finish_recovery(exp_new, "R7 relocated reset");
    chk("R6 free map", 32'(slot_free), 32'(exp_free));
    chk("R6 bad map", 32'(slot_bad), 32'(exp_bad));
  endtask

  task automatic t_no_slot();
    send(2'd0, 1'b1);
    wait_hi(6, "R8 unrecoverable");
    chk("R8 no cfg", 32'({cfg_req, mode_switch}), 32'd0);
    @(negedge clk);
    chk("R8 back idle", 32'({flt_ready, unrecoverable}), 32'b10);
    chk("R6 bad stays", 32'(slot_bad), 32'b0110);
  endtask

  task automatic t_timeout();
    int n = 0;
    send(2'd0, 1'b0);
    wait_hi(0, "R9 cfg_req");
    while (!abort && n < 100) begin @(negedge clk); n++; end
    chk("R9 abort after TIMEOUT", 32'(n), 32'(TO));
    @(negedge clk);
    chk("R9 idle after abort", 32'({flt_ready, abort}), 32'b10);
  endtask

  task automatic t_last_cycle();
    send(2'd3, 1'b0);
    wait_hi(0, "R9 cfg_req");
    repeat (TO - 1) @(negedge clk);
    chk("R10 still waiting", 32'({cfg_req, abort}), 32'b10);
    pulse_cfg();
    chk("R9 last-cycle done wins", 32'({unit_rst, abort}), 32'b10);
    finish_recovery(2'd3, "R9 recover after late done");
  endtask

  task automatic t_held_fault();
    send(2'd0, 1'b0);
    @(negedge clk);
    flt_valid = 1'b1; flt_slot = 2'd3; flt_perm = 1'b0;
    wait_hi(0, "R1 first cfg");
    chk("R1 first slot", 32'(cfg_slot), 32'd0);
    chk("R1 held beat blocked", 32'(flt_ready), 32'd0);
    pulse_cfg();
    wait_hi(3, "R7 first reset");
    @(negedge clk);
    sync_done = 1'b1; @(negedge clk); sync_done = 1'b0;
    chk("R1 blocked during repair_ok", 32'({repair_ok, flt_ready}), 32'b10);
    @(negedge clk);
    chk("R1 ready for held beat", 32'(flt_ready), 32'd1);
    @(posedge clk); #1; flt_valid = 1'b0;
    wait_hi(0, "R1 second cfg");
    chk("R1 held payload served", 32'(cfg_slot), 32'd3);
    pulse_cfg();
    finish_recovery(2'd3, "R7 second reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_transient();
    t_perm(2'd0, 2'd2, 1'b1, 4'b1001, 4'b0000);
    t_perm(2'd2, 2'd0, 1'b0, 4'b1000, 4'b0100);
    t_perm(2'd1, 2'd3, 1'b0, 4'b0000, 4'b0110);
    t_no_slot();
    t_timeout();
    t_last_cycle();
    t_held_fault();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule